// File: doc/BRIEF.md
# Pseudo-SRAM Power-State Sequencer

This block sits between a memory access controller and a self-refreshing pseudo-SRAM. It owns the two chip-select lines of the memory. After the supply becomes valid it holds the memory deselected for a long initialisation hold. It then moves the part through four conditions:

- an active condition, in which the access controller may run cycles;
- a light standby, in which the part is deselected and keeps its contents;
- a deep power-down, in which internal refresh stops and the contents are lost;
- a recovery hold after deep power-down, which is the second long wait.

Every wait is counted in clock cycles. The counts are derived from a clock-frequency parameter and from time parameters given in microseconds and nanoseconds, rounded up to whole cycles. The access controller sees a single access-permitted level. The host sees a sticky flag that reports that memory contents were lost.

The inputs are used as follows. A power-down request first moves the block from active to standby. A second power-down request moves it from standby into deep power-down. A wake request returns the block from standby to active at once. From deep power-down, a wake request starts the recovery hold, and only once the minimum power-down time has passed. A wake request that comes early is remembered until that time is met. Requests are accepted only while the access controller reports no access in progress. A drop of the supply-good input sends the block back to initialisation from any state.

Top module: `psram_pwr_seq`

## Requirements
- R1: While reset is asserted, and after it until the supply hold completes, the block drives cs1_n=1, cs2=1, access_ok=0 and data_lost=0.
- R2: access_ok first rises on the (UP_CYC+1)-th rising clock edge at which supply_ok is sampled high, where UP_CYC = ceil(CLK_HZ*UP_HOLD_US/1e6); after UP_CYC such edges it is still low.
- R3: supply_ok sampled low in any state gives access_ok=0, cs1_n=1 and cs2=1 after that edge, and the full power-up hold of R2 restarts from the next edge with supply_ok high.
- R4: In the active state the outputs are cs1_n=0, cs2=1 and access_ok=1.
- R5: In the active state, pd_req with access_busy=0 gives standby after the next edge: cs1_n=1, cs2=1, access_ok=0. While access_busy=1, pd_req and wake_req have no effect in any state.
- R6: In standby, wake_req returns the block to active after the next edge, with no hold. In standby, wake_req has priority over pd_req.
- R7: In standby, pd_req enters deep power-down after the next edge (cs2=0, cs1_n=1). cs2 only falls after a cycle in which cs1_n was already 1, and cs2=0 always implies cs1_n=1.
- R8: In deep power-down, cs2 stays low for at least PD_CYC+1 cycles, where PD_CYC = ceil(CLK_HZ*PD_MIN_NS/1e9). A wake_req that arrives earlier is held, so cs2 rises exactly PD_CYC+1 edges after entry. Without a wake_req, cs2 stays low indefinitely.
- R9: When cs2 rises on leaving deep power-down, access_ok stays low, with cs1_n=1, for EXIT_CYC further edges and rises on the next one, where EXIT_CYC = ceil(CLK_HZ*EXIT_HOLD_US/1e6).
- R10: data_lost becomes 1 in the same cycle as cs2 rises when leaving deep power-down. It stays 1 through other state changes until clr_lost is sampled high with no new loss in that cycle, which clears it.
- R11: access_ok is 1 only in the active state, and access_ok=1 always implies cs1_n=0 and cs2=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok | input | 1 | Memory supply is valid |
| pd_req | input | 1 | Request to step down (active to standby, standby to deep power-down) |
| wake_req | input | 1 | Request to return to active |
| access_busy | input | 1 | Access controller has a cycle in progress |
| clr_lost | input | 1 | Host clears the data-lost flag |
| cs1_n | output | 1 | Memory chip select 1, active low |
| cs2 | output | 1 | Memory chip select 2; low means deep power-down |
| access_ok | output | 1 | Access controller may start cycles |
| data_lost | output | 1 | Sticky: memory contents were lost in deep power-down |

## Verification
The bench builds the block with a 125 MHz clock, a 2 µs power-up hold, a 1 µs recovery hold and a 200 ns minimum power-down time. These give holds of 250, 125 and 25 cycles. The holds are short enough that every path can be walked edge by edge: full initialisation, a supply drop in the middle of a hold, early and late wake from deep power-down, and the recovery hold. The holds stay distinct enough that a swapped or shared count shows up at the exact edge where access_ok rises. The power-down minimum is far shorter than both holds, so the asymmetry between entering and leaving power-down is visible within one short run.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

   typedef enum logic [2:0] {
      PS_INIT    = 3'd0,
      PS_ACTIVE  = 3'd1,
      PS_STANDBY = 3'd2,
      PS_DEEP    = 3'd3,
      PS_EXIT    = 3'd4
   } pwr_state_e;

   typedef struct packed {
      logic cs1_n;
      logic cs2;
      logic acc_ok;
   } pin_set_t;

   // Pin levels that belong to each state.
   function automatic pin_set_t pins_of(input pwr_state_e s);
      pin_set_t p;
      p.cs1_n  = 1'b1;
      p.cs2    = 1'b1;
      p.acc_ok = 1'b0;
      case (s)
         PS_ACTIVE: begin
            p.cs1_n  = 1'b0;
            p.acc_ok = 1'b1;
         end
         PS_DEEP:   p.cs2 = 1'b0;
         default:   ;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/psram_hold_timer.sv
module psram_hold_timer #(
   parameter int unsigned W         = 8,
   parameter logic [W-1:0] RST_VAL  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= RST_VAL;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

   // R8: a freshly loaded nonzero count is not already expired
   load_not_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val != '0) |=> !zero);

endmodule

// File: rtl/psram_lost_flag.sv
module psram_lost_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag <= 1'b0;
      else if (set)
         flag <= 1'b1;
      else if (clr)
         flag <= 1'b0;
   end

   // R10: without a clear the flag never drops
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);

endmodule

// File: rtl/psram_pwr_fsm.sv
module psram_pwr_fsm
   import psram_pwr_pkg::*;
#(
   parameter int unsigned W            = 8,
   parameter logic [W-1:0] UP_VAL      = '0,
   parameter logic [W-1:0] PD_VAL      = '0,
   parameter logic [W-1:0] EXIT_VAL    = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         supply_ok,
   input  logic         pd_req,
   input  logic         wake_req,
   input  logic         access_busy,
   input  logic         tmr_zero,
   output pwr_state_e   state_q,
   output pwr_state_e   state_d,
   output logic         tmr_load,
   output logic [W-1:0] tmr_val,
   output logic         lost_set
);

   logic pend_q, pend_d;
   logic pd_acc, wake_acc;

   assign pd_acc   = pd_req   && !access_busy;
   assign wake_acc = wake_req && !access_busy;

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = UP_VAL;
      lost_set = 1'b0;
      if (!supply_ok) begin
         state_d  = PS_INIT;
         tmr_load = 1'b1;
         tmr_val  = UP_VAL;
         lost_set = (state_q == PS_DEEP);
      end else begin
         case (state_q)
            PS_INIT:
               if (tmr_zero) state_d = PS_ACTIVE;
            PS_ACTIVE:
               if (pd_acc) state_d = PS_STANDBY;
            PS_STANDBY:
               if (wake_acc) begin
                  state_d = PS_ACTIVE;
               end else if (pd_acc) begin
                  state_d  = PS_DEEP;
                  tmr_load = 1'b1;
                  tmr_val  = PD_VAL;
               end
            PS_DEEP:
               if (tmr_zero && (pend_q || wake_acc)) begin
                  state_d  = PS_EXIT;
                  tmr_load = 1'b1;
                  tmr_val  = EXIT_VAL;
                  lost_set = 1'b1;
               end
            PS_EXIT:
               if (tmr_zero) state_d = PS_ACTIVE;
            default: begin
               state_d  = PS_INIT;
               tmr_load = 1'b1;
               tmr_val  = UP_VAL;
            end
         endcase
      end
   end

   assign pend_d = (state_q == PS_DEEP) && (state_d == PS_DEEP) && (pend_q || wake_acc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PS_INIT;
         pend_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         pend_q  <= pend_d;
      end
   end

   // R6: standby with an accepted wake always reaches active
   standby_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_STANDBY && wake_acc && supply_ok) |=> state_q == PS_ACTIVE);

   // R5: a busy access controller freezes the request-driven states
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (access_busy && supply_ok && (state_q == PS_ACTIVE || state_q == PS_STANDBY))
      |=> $stable(state_q));

endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
   import psram_pwr_pkg::*;
#(
   parameter int unsigned CLK_HZ       = 100_000_000,
   parameter int unsigned UP_HOLD_US   = 300,
   parameter int unsigned EXIT_HOLD_US = 300,
   parameter int unsigned PD_MIN_NS    = 30,
   parameter bit          REG_OUTPUTS  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok,
   input  logic pd_req,
   input  logic wake_req,
   input  logic access_busy,
   input  logic clr_lost,
   output logic cs1_n,
   output logic cs2,
   output logic access_ok,
   output logic data_lost
);

   localparam longint unsigned UP_CYC_L =
      (longint'(CLK_HZ) * longint'(UP_HOLD_US) + 64'd999_999) / 64'd1_000_000;
   localparam longint unsigned EXIT_CYC_L =
      (longint'(CLK_HZ) * longint'(EXIT_HOLD_US) + 64'd999_999) / 64'd1_000_000;
   localparam longint unsigned PD_CYC_L =
      (longint'(CLK_HZ) * longint'(PD_MIN_NS) + 64'd999_999_999) / 64'd1_000_000_000;
   localparam longint unsigned MAX_L =
      (UP_CYC_L > EXIT_CYC_L) ? ((UP_CYC_L > PD_CYC_L) ? UP_CYC_L : PD_CYC_L)
                              : ((EXIT_CYC_L > PD_CYC_L) ? EXIT_CYC_L : PD_CYC_L);
   localparam int unsigned CNT_W = $clog2(MAX_L + 1);
   localparam logic [CNT_W-1:0] UP_VAL   = CNT_W'(UP_CYC_L);
   localparam logic [CNT_W-1:0] EXIT_VAL = CNT_W'(EXIT_CYC_L);
   localparam logic [CNT_W-1:0] PD_VAL   = CNT_W'(PD_CYC_L);

   initial begin
      clk_hz_chk:   assert (CLK_HZ >= 1000)   else $error("CLK_HZ too small");
      up_hold_chk:  assert (UP_HOLD_US > 0)   else $error("UP_HOLD_US must be nonzero");
      exit_hold_chk: assert (EXIT_HOLD_US > 0) else $error("EXIT_HOLD_US must be nonzero");
      pd_min_chk:   assert (PD_MIN_NS > 0)    else $error("PD_MIN_NS must be nonzero");
   end

   pwr_state_e          state_q, state_d;
   logic                tmr_load, tmr_zero, lost_set;
   logic [CNT_W-1:0]    tmr_val;

   psram_pwr_fsm #(
      .W        (CNT_W),
      .UP_VAL   (UP_VAL),
      .PD_VAL   (PD_VAL),
      .EXIT_VAL (EXIT_VAL)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .supply_ok   (supply_ok),
      .pd_req      (pd_req),
      .wake_req    (wake_req),
      .access_busy (access_busy),
      .tmr_zero    (tmr_zero),
      .state_q     (state_q),
      .state_d     (state_d),
      .tmr_load    (tmr_load),
      .tmr_val     (tmr_val),
      .lost_set    (lost_set)
   );

   psram_hold_timer #(
      .W       (CNT_W),
      .RST_VAL (UP_VAL)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   psram_lost_flag u_lost (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (lost_set),
      .clr   (clr_lost),
      .flag  (data_lost)
   );

   // Pin drive: either flops loaded from the next state or decode of the
   // current state; both give the same cycle timing.
   generate
      if (REG_OUTPUTS) begin : g_reg_pins
         pin_set_t pins_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pins_q <= pins_of(PS_INIT);
            else
               pins_q <= pins_of(state_d);
         end
         assign cs1_n     = pins_q.cs1_n;
         assign cs2       = pins_q.cs2;
         assign access_ok = pins_q.acc_ok;
      end else begin : g_dec_pins
         pin_set_t pins_c;
         assign pins_c    = pins_of(state_q);
         assign cs1_n     = pins_c.cs1_n;
         assign cs2       = pins_c.cs2;
         assign access_ok = pins_c.acc_ok;
      end
   endgenerate

   // Counts cycles with cs2 low, for the minimum power-down check.
   logic [CNT_W:0] low_cnt_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         low_cnt_q <= '0;
      else if (cs2)
         low_cnt_q <= '0;
      else if (low_cnt_q != (CNT_W+1)'(PD_CYC_L + 1))
         low_cnt_q <= low_cnt_q + 1'b1;
   end

   // R7
   cs2_low_cs1_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs2 |-> cs1_n);

   // R7
   cs2_fall_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs2) |-> $past(cs1_n));

   // R8
   pd_min_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cs2) && $past(supply_ok)) |-> low_cnt_q >= (CNT_W+1)'(PD_CYC_L + 1));

   // R11
   access_only_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      access_ok |-> (!cs1_n && cs2));

   // R3
   supply_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> (!access_ok && cs1_n && cs2));

   // R10
   lost_with_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_lost) |-> $rose(cs2));

endmodule

// File: tb/tb_psram_pwr_seq.sv
`timescale 1ns/1ps
module tb_psram_pwr_seq;

   localparam int unsigned CLK_HZ  = 125_000_000;
   localparam int unsigned UP_US   = 2;
   localparam int unsigned EXIT_US = 1;
   localparam int unsigned PD_NS   = 200;
   localparam int UP_N   = int'((longint'(CLK_HZ) * UP_US + 999_999) / 1_000_000);
   localparam int EXIT_N = int'((longint'(CLK_HZ) * EXIT_US + 999_999) / 1_000_000);
   localparam int PD_N   = int'((longint'(CLK_HZ) * PD_NS + 999_999_999) / 1_000_000_000);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic supply_ok = 1'b0, pd_req = 1'b0, wake_req = 1'b0;
   logic access_busy = 1'b0, clr_lost = 1'b0;
   logic cs1_n, cs2, access_ok, data_lost;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   psram_pwr_seq #(
      .CLK_HZ       (CLK_HZ),
      .UP_HOLD_US   (UP_US),
      .EXIT_HOLD_US (EXIT_US),
      .PD_MIN_NS    (PD_NS)
   ) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .supply_ok   (supply_ok),
      .pd_req      (pd_req),
      .wake_req    (wake_req),
      .access_busy (access_busy),
      .clr_lost    (clr_lost),
      .cs1_n       (cs1_n),
      .cs2         (cs2),
      .access_ok   (access_ok),
      .data_lost   (data_lost)
   );

   task automatic step(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic chk_pins(input string req, input int e_cs1, input int e_cs2, input int e_ok);
      chk(req, "cs1_n", int'(cs1_n), e_cs1);
      chk(req, "cs2", int'(cs2), e_cs2);
      chk(req, "access_ok", int'(access_ok), e_ok);
   endtask

   task automatic t_reset_powerup();
      step(2);
      chk_pins("R1", 1, 1, 0);
      chk("R1", "data_lost", int'(data_lost), 0);
      rst_n = 1'b1;
      step(3);
      chk_pins("R1", 1, 1, 0);
      supply_ok = 1'b1;
      step(UP_N);
      chk_pins("R2", 1, 1, 0);
      step(1);
      chk_pins("R4", 0, 1, 1);
   endtask

   task automatic t_supply_drop();
      supply_ok = 1'b0;
      step(1);
      chk_pins("R3", 1, 1, 0);
      supply_ok = 1'b1;
      step(100);
      supply_ok = 1'b0;
      step(1);
      supply_ok = 1'b1;
      step(UP_N);
      chk_pins("R3", 1, 1, 0);
      step(1);
      chk_pins("R3", 0, 1, 1);
   endtask

   task automatic t_standby();
      access_busy = 1'b1;
      pd_req = 1'b1;
      step(1);
      chk_pins("R5", 0, 1, 1);
      access_busy = 1'b0;
      step(1);
      pd_req = 1'b0;
      chk_pins("R5", 1, 1, 0);
      step(5);
      chk_pins("R11", 1, 1, 0);
      access_busy = 1'b1;
      wake_req = 1'b1;
      step(1);
      chk_pins("R5", 1, 1, 0);
      access_busy = 1'b0;
      pd_req = 1'b1;
      step(1);
      wake_req = 1'b0;
      pd_req = 1'b0;
      chk_pins("R6", 0, 1, 1);
      chk("R10", "data_lost", int'(data_lost), 0);
   endtask

   task automatic t_deep_early_wake();
      pd_req = 1'b1;
      step(1);
      chk_pins("R5", 1, 1, 0);
      step(1);
      pd_req = 1'b0;
      chk_pins("R7", 1, 0, 0);
      wake_req = 1'b1;
      step(1);
      wake_req = 1'b0;
      step(PD_N - 1);
      chk_pins("R8", 1, 0, 0);
      step(1);
      chk_pins("R8", 1, 1, 0);
      chk("R10", "data_lost", int'(data_lost), 1);
      step(EXIT_N);
      chk_pins("R9", 1, 1, 0);
      step(1);
      chk_pins("R9", 0, 1, 1);
      chk("R10", "data_lost", int'(data_lost), 1);
   endtask

   task automatic t_clear_and_late_wake();
      clr_lost = 1'b1;
      step(1);
      clr_lost = 1'b0;
      chk("R10", "data_lost", int'(data_lost), 0);
      pd_req = 1'b1;
      step(2);
      pd_req = 1'b0;
      chk_pins("R7", 1, 0, 0);
      step(PD_N + 10);
      chk_pins("R8", 1, 0, 0);
      access_busy = 1'b1;
      wake_req = 1'b1;
      step(1);
      chk_pins("R5", 1, 0, 0);
      access_busy = 1'b0;
      step(1);
      wake_req = 1'b0;
      chk_pins("R8", 1, 1, 0);
      chk("R10", "data_lost", int'(data_lost), 1);
      step(EXIT_N);
      chk_pins("R9", 1, 1, 0);
      step(1);
      chk_pins("R9", 0, 1, 1);
   endtask

   initial begin
      t_reset_powerup();
      t_supply_drop();
      t_standby();
      t_deep_early_wake();
      t_clear_and_late_wake();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule